// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block chooses the fastest DMA transfer mode that a host port and an attached drive both support, without going above a mode the caller asks for. It takes the drive's capability masks for the three DMA families (Ultra, multiword, single-word) and two validity flags that say which of those masks are meaningful. It also takes the host's own capability masks, an 80-wire cable detect, a legacy single-word timing number, a media-is-disk flag and a host flag that forbids DMA to packet (non-disk) devices.

The families are tried in a fixed order, fastest first. Each family has its own base code, and a found mode is that base plus the index of the highest bit common to host and drive. The result is then limited to the requested code. It is captured on a one-cycle request strobe and announced with a one-cycle valid pulse. A result code of 0 means that DMA must not be used.

Top module: `dma_mode_sel`

## Requirements
- R1: While rst_n is low, mode_o is 0 and valid_o is 0; a reset applied after a result clears mode_o back to 0.
- R2: valid_o is 1 in exactly the cycle after each cycle with req_i high, and 0 otherwise. mode_o changes only in the cycle after a strobe and holds its value between strobes, whatever the inputs do.
- R3: Families are searched Ultra (base 0x40), then multiword (base 0x20), then single-word (base 0x10). The first family with a nonzero effective mask gives the found mode, and a family with an empty mask passes the search on to the next one.
- R4: A family is skipped when req_mode_i is below its base code. A request below 0x10 therefore gives 0.
- R5: Within a family, the found mode is the base code plus the bit index of the highest set bit of (host mask AND drive mask).
- R6: The Ultra family is considered only when id_valid_i[2] is 1. The multiword family is considered only when id_valid_i[1] is 1.
- R7: When req_mode_i is above 0x42, cable80_i is 0 and the Ultra mask has any of bits 6:3 set, the Ultra mask is cut to its bits 2:0.
- R8: For single-word, id_valid_i[1]=1 uses the drive's single-word mask. Otherwise sw_timing_i values 0, 1 and 2 give the masks 0x01, 0x03 and 0x07, ANDed with the host single-word mask, and larger values give an empty mask.
- R9: The captured mode is the smaller of the found mode and req_mode_i.
- R10: When is_disk_i is 0 and host_no_atapi_i is 1, the captured mode is 0. When is_disk_i is 0 and host_no_atapi_i is 0, the selection runs as for a disk.
- R11: When no family yields a nonzero mask, the captured mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle strobe that captures a new selection |
| req_mode_i | input | 8 | Requested (ceiling) mode code |
| id_valid_i | input | 2 | Drive validity flags, bits [2:1]: bit 2 Ultra, bit 1 multiword/single-word |
| drv_udma_i | input | 8 | Drive Ultra capability mask |
| drv_mwdma_i | input | 8 | Drive multiword capability mask |
| drv_swdma_i | input | 8 | Drive single-word capability mask |
| host_udma_i | input | 8 | Host Ultra capability mask |
| host_mwdma_i | input | 8 | Host multiword capability mask |
| host_swdma_i | input | 8 | Host single-word capability mask |
| cable80_i | input | 1 | 80-wire cable detected |
| sw_timing_i | input | 8 | Legacy single-word timing mode number |
| is_disk_i | input | 1 | Attached media is a disk |
| host_no_atapi_i | input | 1 | Host forbids DMA to non-disk media |
| mode_o | output | 8 | Selected mode code, 0 for no DMA |
| valid_o | output | 1 | One-cycle pulse after each strobe |

## Verification
The selection is driven with capability sets that make a single family win: Ultra alone, multiword with the Ultra flag cleared, and single-word through both the drive mask and the legacy timing number. These show that the priority order and the validity gates are honoured. Pairs that differ in only one input separate the cable clip from the request cap, and separate a host mask that is narrower than the drive's from one that is wider. Requests just below each base code confirm that families are skipped. Non-disk media are tried with and without the host prohibition, and the strobe timing is checked with back-to-back strobes, idle cycles with changing inputs, and a reset applied after a result.

// File: rtl/dma_mode_pkg.sv
package dma_mode_pkg;

  // Base codes of the three transfer families; the search runs in index order.
  localparam int unsigned ULTRA_BASE = 32'h40;
  localparam int unsigned MWORD_BASE = 32'h20;
  localparam int unsigned SWORD_BASE = 32'h10;
  localparam int unsigned NUM_CLS    = 3;

  // Ultra mask bits that need an 80-wire cable, and the highest mode that does not.
  localparam int unsigned CLIP_LO      = 3;
  localparam int unsigned CLIP_HI      = 6;
  localparam int unsigned CABLE_LIMIT  = ULTRA_BASE + CLIP_LO - 1;

  // Largest legacy single-word timing number that maps to a mask.
  localparam int unsigned SW_TIMING_MAX = 2;

  typedef enum logic [1:0] {
    CLS_ULTRA = 2'd0,
    CLS_MWORD = 2'd1,
    CLS_SWORD = 2'd2
  } dma_cls_e;

endpackage

// File: rtl/dma_class_mask.sv
module dma_class_mask #(
  parameter int unsigned MASK_W  = 8,
  parameter int unsigned CLIP_LO = 3,
  parameter int unsigned CLIP_HI = 6
) (
  input  logic              gate_i,
  input  logic [MASK_W-1:0] drv_i,
  input  logic [MASK_W-1:0] host_i,
  input  logic [MASK_W-1:0] alt_i,
  input  logic              clip_req_i,
  output logic [MASK_W-1:0] mask_o
);

  localparam logic [MASK_W-1:0] KEEP_MASK = MASK_W'((1 << CLIP_LO) - 1);
  localparam logic [MASK_W-1:0] HIGH_MASK = MASK_W'((1 << (CLIP_HI + 1)) - 1) & ~KEEP_MASK;

  logic [MASK_W-1:0] common;

  // A family whose validity flag is clear falls back to the alternate mask.
  always_comb begin
    common = gate_i ? (drv_i & host_i) : alt_i;
    if (clip_req_i && ((common & HIGH_MASK) != '0)) begin
      mask_o = common & KEEP_MASK;
    end else begin
      mask_o = common;
    end
  end

endmodule

// File: rtl/dma_mode_pick.sv
module dma_mode_pick #(
  parameter int unsigned MODE_W = 8,
  parameter int unsigned MASK_W = 8,
  parameter int unsigned NCLS   = 3,
  parameter int unsigned IDX_W  = $clog2(MASK_W)
) (
  input  logic [NCLS-1:0][MASK_W-1:0] mask_i,
  input  logic [NCLS-1:0][MODE_W-1:0] base_i,
  input  logic [MODE_W-1:0]           req_mode_i,
  output logic [MODE_W-1:0]           found_o
);

  function automatic logic [IDX_W-1:0] top_bit(input logic [MASK_W-1:0] m);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int b = 0; b < MASK_W; b++) begin
      if (m[b]) idx = IDX_W'(b);
    end
    return idx;
  endfunction

  // Walk from the slowest family upwards so that the fastest eligible one
  // (index 0) is the last writer and wins.
  always_comb begin
    found_o = '0;
    for (int c = NCLS - 1; c >= 0; c--) begin
      if ((req_mode_i >= base_i[c]) && (mask_i[c] != '0)) begin
        found_o = base_i[c] + MODE_W'(top_bit(mask_i[c]));
      end
    end
  end

endmodule

// File: rtl/dma_mode_sel.sv
module dma_mode_sel
  import dma_mode_pkg::*;
#(
  parameter int unsigned MODE_W  = 8,
  parameter int unsigned MASK_W  = 8,
  parameter int unsigned TMODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [MODE_W-1:0] req_mode_i,
  input  logic [2:1]        id_valid_i,
  input  logic [MASK_W-1:0] drv_udma_i,
  input  logic [MASK_W-1:0] drv_mwdma_i,
  input  logic [MASK_W-1:0] drv_swdma_i,
  input  logic [MASK_W-1:0] host_udma_i,
  input  logic [MASK_W-1:0] host_mwdma_i,
  input  logic [MASK_W-1:0] host_swdma_i,
  input  logic              cable80_i,
  input  logic [TMODE_W-1:0] sw_timing_i,
  input  logic              is_disk_i,
  input  logic              host_no_atapi_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              valid_o
);

  localparam int unsigned NCLS = NUM_CLS;
  localparam logic [NCLS-1:0][MODE_W-1:0] CLS_BASE = {
    MODE_W'(SWORD_BASE), MODE_W'(MWORD_BASE), MODE_W'(ULTRA_BASE)
  };
  localparam logic [MASK_W-1:0] ULTRA_HIGH =
    MASK_W'((1 << (CLIP_HI + 1)) - 1) & ~MASK_W'((1 << CLIP_LO) - 1);

  // Legacy timing number -> single-word mask: 0 -> 1, 1 -> 3, 2 -> 7.
  function automatic logic [MASK_W-1:0] legacy_mask(input logic [TMODE_W-1:0] t);
    if (t <= TMODE_W'(SW_TIMING_MAX)) return MASK_W'((2 << t) - 1);
    return '0;
  endfunction

  function automatic logic [MODE_W-1:0] min_mode(input logic [MODE_W-1:0] a,
                                                 input logic [MODE_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // Named internal events, observed by the assertions below.
  logic                          clip_req;
  logic                          atapi_block;
  logic [NCLS-1:0]               cls_gate;
  logic [NCLS-1:0]               cls_clip;
  logic [NCLS-1:0][MASK_W-1:0]   cls_drv;
  logic [NCLS-1:0][MASK_W-1:0]   cls_host;
  logic [NCLS-1:0][MASK_W-1:0]   cls_alt;
  logic [NCLS-1:0][MASK_W-1:0]   cls_mask;
  logic [MODE_W-1:0]             found_mode;
  logic [MODE_W-1:0]             next_mode;
  logic [MODE_W-1:0]             mode_q;
  logic                          valid_q;

  assign clip_req    = (req_mode_i > MODE_W'(CABLE_LIMIT)) && !cable80_i;
  assign atapi_block = !is_disk_i && host_no_atapi_i;

  always_comb begin
    cls_gate[CLS_ULTRA] = id_valid_i[2];
    cls_gate[CLS_MWORD] = id_valid_i[1];
    cls_gate[CLS_SWORD] = id_valid_i[1];
    cls_clip            = '0;
    cls_clip[CLS_ULTRA] = clip_req;
    cls_drv[CLS_ULTRA]  = drv_udma_i;
    cls_drv[CLS_MWORD]  = drv_mwdma_i;
    cls_drv[CLS_SWORD]  = drv_swdma_i;
    cls_host[CLS_ULTRA] = host_udma_i;
    cls_host[CLS_MWORD] = host_mwdma_i;
    cls_host[CLS_SWORD] = host_swdma_i;
    cls_alt             = '0;
    cls_alt[CLS_SWORD]  = legacy_mask(sw_timing_i) & host_swdma_i;
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    dma_class_mask #(
      .MASK_W  (MASK_W),
      .CLIP_LO (CLIP_LO),
      .CLIP_HI (CLIP_HI)
    ) u_mask (
      .gate_i     (cls_gate[c]),
      .drv_i      (cls_drv[c]),
      .host_i     (cls_host[c]),
      .alt_i      (cls_alt[c]),
      .clip_req_i (cls_clip[c]),
      .mask_o     (cls_mask[c])
    );
  end

  dma_mode_pick #(
    .MODE_W (MODE_W),
    .MASK_W (MASK_W),
    .NCLS   (NCLS)
  ) u_pick (
    .mask_i     (cls_mask),
    .base_i     (CLS_BASE),
    .req_mode_i (req_mode_i),
    .found_o    (found_mode)
  );

  assign next_mode = atapi_block ? '0 : min_mode(found_mode, req_mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_i;
      if (req_i) mode_q <= next_mode;
    end
  end

  assign mode_o  = mode_q;
  assign valid_o = valid_q;

  // R2: one valid pulse per strobe, nothing without a strobe
  p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> valid_o);
  p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !valid_o);
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(mode_o));

  // R9: the captured mode never exceeds the request it answered
  p_cap_by_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (mode_o <= $past(req_mode_i)));

  // R10: non-disk media under the host prohibition get no DMA
  p_atapi_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !is_disk_i && host_no_atapi_i) |=> (mode_o == '0));

  // R7: no cable-dependent Ultra bit survives the clip
  p_cable_clip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clip_req |-> ((cls_mask[CLS_ULTRA] & ULTRA_HIGH) == '0));

  // R6: the validity flags gate the Ultra and multiword families
  p_ultra_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid_i[2] |-> (cls_mask[CLS_ULTRA] == '0));
  p_mword_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid_i[1] |-> (cls_mask[CLS_MWORD] == '0));

  // R4: a request below the slowest base never finds a mode
  p_below_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode_i < MODE_W'(SWORD_BASE)) |-> (found_mode == '0));

endmodule

// File: tb/dma_mode_sel_tb_top.sv
`timescale 1ns/1ps
module dma_mode_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0;
  logic [7:0] req_mode_i = '0;
  logic [2:1] id_valid_i = '0;
  logic [7:0] drv_udma_i = '0, drv_mwdma_i = '0, drv_swdma_i = '0;
  logic [7:0] host_udma_i = '0, host_mwdma_i = '0, host_swdma_i = '0;
  logic       cable80_i = 1'b0;
  logic [7:0] sw_timing_i = '0;
  logic       is_disk_i = 1'b1;
  logic       host_no_atapi_i = 1'b0;
  logic [7:0] mode_o;
  logic       valid_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dma_mode_sel dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_mode_i(req_mode_i),
    .id_valid_i(id_valid_i), .drv_udma_i(drv_udma_i), .drv_mwdma_i(drv_mwdma_i),
    .drv_swdma_i(drv_swdma_i), .host_udma_i(host_udma_i), .host_mwdma_i(host_mwdma_i),
    .host_swdma_i(host_swdma_i), .cable80_i(cable80_i), .sw_timing_i(sw_timing_i),
    .is_disk_i(is_disk_i), .host_no_atapi_i(host_no_atapi_i),
    .mode_o(mode_o), .valid_o(valid_o)
  );

  typedef struct packed {
    logic [7:0] rq;
    logic [2:1] vld;
    logic [7:0] du, dm, ds, hu, hm, hs;
    logic       cab;
    logic [7:0] tm;
    logic       dsk, noat;
    logic [7:0] exp;
    logic [7:0] rid;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    // R3 R5: Ultra wins, highest common bit 5
    '{rq:8'h46, vld:2'b11, du:8'h3F, dm:8'h07, ds:8'h07, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd0, dsk:1'b1, noat:1'b0, exp:8'h45, rid:8'd5},
    // R7: no 80-wire cable, request above 0x42 -> clipped to bits 2:0
    '{rq:8'h46, vld:2'b11, du:8'h3F, dm:8'h07, ds:8'h07, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b0, tm:8'd0, dsk:1'b1, noat:1'b0, exp:8'h42, rid:8'd7},
    // R9: found 0x45 capped by request 0x43
    '{rq:8'h43, vld:2'b11, du:8'h3F, dm:8'h07, ds:8'h07, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd0, dsk:1'b1, noat:1'b0, exp:8'h43, rid:8'd9},
    // R6: Ultra flag clear -> multiword 0x22
    '{rq:8'h46, vld:2'b01, du:8'h3F, dm:8'h07, ds:8'h07, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd0, dsk:1'b1, noat:1'b0, exp:8'h22, rid:8'd6},
    // R8: multiword flag clear, legacy timing 1 -> mask 0x03 -> 0x11
    '{rq:8'h46, vld:2'b10, du:8'h00, dm:8'h07, ds:8'h07, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd1, dsk:1'b1, noat:1'b0, exp:8'h11, rid:8'd8},
    // R11: legacy timing 3 gives nothing, no family left
    '{rq:8'h46, vld:2'b00, du:8'h3F, dm:8'h07, ds:8'h07, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd3, dsk:1'b1, noat:1'b0, exp:8'h00, rid:8'd11},
    // R8: legacy timing 2 -> 0x07 AND host 0x03 -> 0x11
    '{rq:8'h46, vld:2'b00, du:8'h3F, dm:8'h07, ds:8'h07, hu:8'h7F, hm:8'h07, hs:8'h03, cab:1'b1, tm:8'd2, dsk:1'b1, noat:1'b0, exp:8'h11, rid:8'd8},
    // R4: request 0x30 skips Ultra -> multiword 0x22
    '{rq:8'h30, vld:2'b11, du:8'h3F, dm:8'h07, ds:8'h07, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd0, dsk:1'b1, noat:1'b0, exp:8'h22, rid:8'd4},
    // R4: request 0x12 skips Ultra and multiword -> single-word 0x12
    '{rq:8'h12, vld:2'b11, du:8'h3F, dm:8'h07, ds:8'h05, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd0, dsk:1'b1, noat:1'b0, exp:8'h12, rid:8'd4},
    // R4: request 0x0F below every base -> 0
    '{rq:8'h0F, vld:2'b11, du:8'h3F, dm:8'h07, ds:8'h07, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd0, dsk:1'b1, noat:1'b0, exp:8'h00, rid:8'd4},
    // R10: non-disk with host prohibition -> 0
    '{rq:8'h46, vld:2'b11, du:8'h3F, dm:8'h07, ds:8'h07, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd0, dsk:1'b0, noat:1'b1, exp:8'h00, rid:8'd10},
    // R10: non-disk without prohibition -> normal 0x45
    '{rq:8'h46, vld:2'b11, du:8'h3F, dm:8'h07, ds:8'h07, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd0, dsk:1'b0, noat:1'b0, exp:8'h45, rid:8'd10},
    // R5: host Ultra mask 0x07 narrower than drive -> 0x42
    '{rq:8'h46, vld:2'b11, du:8'h3F, dm:8'h07, ds:8'h07, hu:8'h07, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd0, dsk:1'b1, noat:1'b0, exp:8'h42, rid:8'd5},
    // R3: empty Ultra and multiword fall through to single-word 0x10
    '{rq:8'h46, vld:2'b11, du:8'h00, dm:8'h00, ds:8'h01, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd0, dsk:1'b1, noat:1'b0, exp:8'h10, rid:8'd3},
    // R8: multiword flag set selects the drive single-word mask (empty), timing ignored
    '{rq:8'h46, vld:2'b01, du:8'h3F, dm:8'h00, ds:8'h00, hu:8'h7F, hm:8'h07, hs:8'h07, cab:1'b1, tm:8'd0, dsk:1'b1, noat:1'b0, exp:8'h00, rid:8'd8}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_vec(input vec_t v);
    req_mode_i      = v.rq;
    id_valid_i      = v.vld;
    drv_udma_i      = v.du;
    drv_mwdma_i     = v.dm;
    drv_swdma_i     = v.ds;
    host_udma_i     = v.hu;
    host_mwdma_i    = v.hm;
    host_swdma_i    = v.hs;
    cable80_i       = v.cab;
    sw_timing_i     = v.tm;
    is_disk_i       = v.dsk;
    host_no_atapi_i = v.noat;
  endtask

  // Strobe one vector; result is sampled at the next falling edge.
  task automatic apply(input vec_t v);
    @(negedge clk);
    drive_vec(v);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  function automatic string tag_of(input logic [7:0] rid);
    return $sformatf("R%0d", rid);
  endfunction

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode_o, 8'h00);
    chk("R1 reset valid", {7'd0, valid_o}, 8'h01 & 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      chk({tag_of(TBL[i].rid), " vector mode"}, mode_o, TBL[i].exp);
      chk("R2 valid pulse", {7'd0, valid_o}, 8'h01);
    end

    // R2: valid drops after one cycle; mode holds while inputs change without a strobe
    apply(TBL[0]);
    @(negedge clk);
    chk("R2 valid low after pulse", {7'd0, valid_o}, 8'h00);
    drive_vec(TBL[9]);
    repeat (2) @(negedge clk);
    chk("R2 mode held without strobe", mode_o, 8'h45);

    // R2: back-to-back strobes update on each cycle
    @(negedge clk);
    drive_vec(TBL[3]);
    req_i = 1'b1;
    @(negedge clk);
    chk("R2 first of pair", mode_o, 8'h22);
    chk("R2 valid first of pair", {7'd0, valid_o}, 8'h01);
    drive_vec(TBL[8]);
    @(negedge clk);
    req_i = 1'b0;
    chk("R2 second of pair", mode_o, 8'h12);
    chk("R2 valid second of pair", {7'd0, valid_o}, 8'h01);

    // R1: reset after a result clears it
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears mode", mode_o, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule